// File: doc/BRIEF.md
# Banked GPIO Interrupt Controller

This block gathers interrupt events from a set of general-purpose input pins, which are grouped into banks of sixteen. It also drives a registered output value onto each pin's output line. Each pin passes through a two-flop synchroniser. Each pin is then watched either for an edge or for a level, and the polarity of each is chosen per pin. A qualifying event sets a sticky status bit, and that bit stays set until software writes a zero over it. A per-pin mask bit stops new events from setting status and also hides any status that is already set.

A top-level status word has one pending bit per bank, which is the OR of that bank's unmasked status bits. Above those bits sit several non-GPIO interrupt sources, brought in as synchronous levels. A top-level control word enables each non-GPIO source and holds a global enable. The single interrupt output is high while the global enable is set and any enabled top-level status bit is set. Software reaches everything through a simple word-addressed register bus: writes take effect on the clock edge and reads are combinational.

Both-edge detection is left to software, which flips a pin's edge polarity after each event.

Top module: `gpio_irq_hub`

## Requirements
- R1: After reset every mask register reads 0xFFFF. Every other bank register, the top-level control word and every status bit read 0, and `irq_out` is low.
- R2: Bank b's registers sit at word address b*8 + offset. The offsets are: 0 output value, 1 pin status (read-only, writes ignored), 2 mask, 3 trigger type, 4 edge polarity, 5 level polarity, 6 interrupt status. Address 32 holds the top-level status (read-only) and address 33 holds the top-level control word.
- R3: The pin status register shows the input pins two clock edges after they change. After only one edge it still shows the old value.
- R4: A trigger-type bit of 1 selects edge mode. In edge mode an edge-polarity bit of 1 catches rising edges only and 0 catches falling edges only. The status bit is visible three edges after the pin changes.
- R5: A trigger-type bit of 0 selects level mode. A level-polarity bit of 1 means active-high and 0 means active-low. While the active level persists and the pin is unmasked, the status bit is set again on every cycle, so a clear does not remove it.
- R6: A mask bit of 1 stops the pin from setting its status bit. It also removes a status bit that is already set from the bank's pending bit and from `irq_out`.
- R7: Status bits are sticky. A write to the status register clears each bit whose write-data bit is 0 and keeps each bit whose write-data bit is 1, so writing 0 clears the whole bank. An event arriving in the same cycle as the clear wins over it.
- R8: Top-level status bits 0..3 are the pending bits of banks 0..3. Bits 4..9 are `ext_src[0..5]`, one cycle after the input. Bits 10..15 read 0.
- R9: In the control word, bits 4..9 enable the matching non-GPIO sources and bit 15 is the global enable. Other bits read 0. Bank pending bits need no enable. `irq_out` is high exactly when bit 15 is set and some enabled status bit is set.
- R10: Each bank's output-value register drives that bank's sixteen bits of `gpio_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| gpio_in | input | 64 | Asynchronous input pins, bank b at bits 16b+15..16b |
| gpio_out | output | 64 | Output value registers, same layout |
| ext_src | input | 6 | Non-GPIO interrupt levels, synchronous |
| irq_out | output | 1 | Aggregated interrupt line |

## Verification
Assertions check five things on every cycle: a masked pin never gains a status bit; status bits only fall on a status write; a zero write with no simultaneous event empties the bank; an unmasked qualifying edge or level always lands in status; and `irq_out` never rises without the global enable and a real enabled cause. The bench's scenarios are needed for the rest. These are the synchroniser latency, the exact per-pin addressing across all sixty-four pins, rising versus falling selection, the partial clear and the level re-set after a clear, and the non-GPIO enable sweep.

// File: rtl/gib_pkg.sv
package gib_pkg;
  localparam int unsigned STRIDE_LOG2 = 3;
  localparam int unsigned EXT_LSB_GAP = 0;

  typedef enum logic [2:0] {
    OFF_OUT  = 3'd0,
    OFF_PIN  = 3'd1,
    OFF_MASK = 3'd2,
    OFF_TRIG = 3'd3,
    OFF_EPOL = 3'd4,
    OFF_LPOL = 3'd5,
    OFF_STS  = 3'd6,
    OFF_RSVD = 3'd7
  } bank_off_e;
endpackage

// File: rtl/gib_sync2.sv
module gib_sync2 #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gib_bank.sv
module gib_bank
  import gib_pkg::*;
#(
  parameter int unsigned PINS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pins_in,
  input  logic            wr_en,
  input  logic [2:0]      off,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] rdata,
  output logic [PINS-1:0] pins_out,
  output logic            pend
);
  logic [PINS-1:0] out_q, mask_q, trig_q, epol_q, lpol_q, sts_q;
  logic [PINS-1:0] pin_s, pin_d;
  logic [PINS-1:0] rise_evt, fall_evt, hit_vec, set_vec;
  logic            clr_wr;
  bank_off_e       off_e;

  function automatic logic [PINS-1:0] pin_hit(
    input logic [PINS-1:0] trig, input logic [PINS-1:0] epol,
    input logic [PINS-1:0] lpol, input logic [PINS-1:0] rise,
    input logic [PINS-1:0] fall, input logic [PINS-1:0] lvl);
    logic [PINS-1:0] edge_hit, level_hit;
    edge_hit  = (epol & rise) | (~epol & fall);
    level_hit = ~(lpol ^ lvl);
    return (trig & edge_hit) | (~trig & level_hit);
  endfunction

  gib_sync2 #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_in), .q(pin_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_d <= '0;
    else        pin_d <= pin_s;
  end

  assign off_e    = bank_off_e'(off);
  assign rise_evt = pin_s & ~pin_d;
  assign fall_evt = ~pin_s & pin_d;
  assign hit_vec  = pin_hit(trig_q, epol_q, lpol_q, rise_evt, fall_evt, pin_s);
  assign set_vec  = hit_vec & ~mask_q;
  assign clr_wr   = wr_en && (off_e == OFF_STS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      mask_q <= '1;
      trig_q <= '0;
      epol_q <= '0;
      lpol_q <= '0;
    end else if (wr_en) begin
      case (off_e)
        OFF_OUT:  out_q  <= wdata;
        OFF_MASK: mask_q <= wdata;
        OFF_TRIG: trig_q <= wdata;
        OFF_EPOL: epol_q <= wdata;
        OFF_LPOL: lpol_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (clr_wr ? (sts_q & wdata) : sts_q) | set_vec;
  end

  always_comb begin
    case (off_e)
      OFF_OUT:  rdata = out_q;
      OFF_PIN:  rdata = pin_s;
      OFF_MASK: rdata = mask_q;
      OFF_TRIG: rdata = trig_q;
      OFF_EPOL: rdata = epol_q;
      OFF_LPOL: rdata = lpol_q;
      OFF_STS:  rdata = sts_q;
      default:  rdata = '0;
    endcase
  end

  assign pins_out = out_q;
  assign pend     = |(sts_q & ~mask_q);

  // R6: a masked pin never gains a status bit
  p_masked_no_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & $past(mask_q)) == '0));

  // R7: without a status write no bit ever falls
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((~sts_q & $past(sts_q)) == '0));

  // R7: a zero write with no coincident event empties the bank
  p_zero_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && wdata == '0 && set_vec == '0) |=> (sts_q == '0));

  // R4: an unmasked edge of the chosen polarity lands in status
  p_edge_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(trig_q & ~mask_q & ((epol_q & rise_evt) | (~epol_q & fall_evt)))
               & ~sts_q) == '0));

  // R5: an unmasked active level lands in status every cycle
  p_level_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(~trig_q & ~mask_q & ((lpol_q & pin_s) | (~lpol_q & ~pin_s)))
               & ~sts_q) == '0));
endmodule

// File: rtl/gpio_irq_hub.sv
module gpio_irq_hub
  import gib_pkg::*;
#(
  parameter int unsigned NBANK = 4,
  parameter int unsigned PINS  = 16,
  parameter int unsigned NEXT  = 6,
  localparam int unsigned NTOP    = NBANK + NEXT,
  localparam int unsigned STS_ADR = NBANK << STRIDE_LOG2,
  localparam int unsigned CTL_ADR = STS_ADR + 1,
  localparam int unsigned ADDR_W  = $clog2(CTL_ADR + 1),
  localparam int unsigned GEN_BIT = PINS - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [PINS-1:0]       bus_wdata,
  output logic [PINS-1:0]       bus_rdata,
  input  logic [NBANK*PINS-1:0] gpio_in,
  output logic [NBANK*PINS-1:0] gpio_out,
  input  logic [NEXT-1:0]       ext_src,
  output logic                  irq_out
);
  logic [PINS-1:0]  bank_rd [NBANK];
  logic [NBANK-1:0] bank_pend;
  logic [NBANK-1:0] bank_we;
  logic [NEXT-1:0]  ext_q;
  logic [PINS-1:0]  ctl_q, top_sts;
  logic [NTOP-1:0]  en_vec;
  logic             in_bank_space;

  function automatic int unsigned bank_of(input logic [ADDR_W-1:0] a);
    return int'(a >> STRIDE_LOG2);
  endfunction

  function automatic logic [PINS-1:0] ctl_wmask();
    logic [PINS-1:0] m;
    m = '0;
    for (int k = NBANK; k < NTOP; k++) m[k] = 1'b1;
    m[GEN_BIT] = 1'b1;
    return m;
  endfunction

  assign in_bank_space = (32'(bus_addr) < STS_ADR);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_we[b] = bus_wr && in_bank_space && (bank_of(bus_addr) == b);
    gib_bank #(.PINS(PINS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .pins_in  (gpio_in[b*PINS +: PINS]),
      .wr_en    (bank_we[b]),
      .off      (bus_addr[2:0]),
      .wdata    (bus_wdata),
      .rdata    (bank_rd[b]),
      .pins_out (gpio_out[b*PINS +: PINS]),
      .pend     (bank_pend[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= '0;
      ctl_q <= '0;
    end else begin
      ext_q <= ext_src;
      if (bus_wr && 32'(bus_addr) == CTL_ADR) ctl_q <= bus_wdata & ctl_wmask();
    end
  end

  always_comb begin
    top_sts = '0;
    top_sts[NTOP-1:0] = {ext_q, bank_pend};
  end

  assign en_vec  = {ctl_q[NTOP-1:NBANK], {NBANK{1'b1}}};
  assign irq_out = ctl_q[GEN_BIT] & (|(top_sts[NTOP-1:0] & en_vec));

  always_comb begin
    if (in_bank_space)                 bus_rdata = bank_rd[bank_of(bus_addr)];
    else if (32'(bus_addr) == STS_ADR) bus_rdata = top_sts;
    else if (32'(bus_addr) == CTL_ADR) bus_rdata = ctl_q;
    else                               bus_rdata = '0;
  end

  // R9: the line needs the global enable and a genuine enabled cause
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (ctl_q[GEN_BIT] &&
                 (bank_pend != '0 || (ext_q & ctl_q[NTOP-1:NBANK]) != '0)));
endmodule

// File: tb/gpio_irq_hub_bench.sv
module gpio_irq_hub_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OFF_OUT = 0, OFF_PIN = 1, OFF_MASK = 2, OFF_TRIG = 3;
  localparam int OFF_EPOL = 4, OFF_LPOL = 5, OFF_STS = 6;
  localparam int STS_A = 32, CTL_A = 33;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [63:0] gpio_in = '0;
  logic [63:0] gpio_out;
  logic [5:0]  ext_src = '0;
  logic        irq_out;
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  gpio_irq_hub u_gpio_irq_hub (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .ext_src(ext_src), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ra(input int bank, input int off);
    return bank * 8 + off;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    bus_addr = a[5:0]; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    bus_addr = a[5:0];
    #1;
    d = bus_rdata;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_reg(input string req, input int a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    for (int b = 0; b < 4; b++) begin
      chk_reg("R1 mask", ra(b, OFF_MASK), 16'hFFFF);
      chk_reg("R1 status", ra(b, OFF_STS), 16'h0000);
      chk_reg("R1 trig", ra(b, OFF_TRIG), 16'h0000);
      chk_reg("R1 out", ra(b, OFF_OUT), 16'h0000);
    end
    chk_reg("R1 ctl", CTL_A, 16'h0000);
    chk_reg("R1 topsts", STS_A, 16'h0000);
    check("R1 irq", {15'd0, irq_out}, 16'h0000);

    // R2 / R10 addressing and output drive
    for (int b = 0; b < 4; b++) begin
      logic [15:0] pat;
      pat = 16'h5A3C ^ (16'h1111 * b[15:0]);
      wr(ra(b, OFF_OUT), pat);
      wr(ra(b, OFF_EPOL), ~pat);
      wr(ra(b, OFF_LPOL), pat + 16'd7);
      wr(ra(b, OFF_PIN), 16'hFFFF);
      check("R10 gpio_out", gpio_out[b*16 +: 16], pat);
      chk_reg("R2 out", ra(b, OFF_OUT), pat);
      chk_reg("R2 epol", ra(b, OFF_EPOL), ~pat);
      chk_reg("R2 lpol", ra(b, OFF_LPOL), pat + 16'd7);
      chk_reg("R2 pin ro", ra(b, OFF_PIN), 16'h0000);
    end

    // R3 synchroniser latency
    gpio_in = 64'hF00D_1234_BEEF_0A50;
    tick(1);
    chk_reg("R3 old", ra(2, OFF_PIN), 16'h0000);
    tick(1);
    for (int b = 0; b < 4; b++) chk_reg("R3 new", ra(b, OFF_PIN), gpio_in[b*16 +: 16]);
    gpio_in = '0;
    tick(3);
    for (int b = 0; b < 4; b++) chk_reg("R6 masked reset", ra(b, OFF_STS), 16'h0000);

    // R4 rising sweep over every pin
    wr(CTL_A, 16'h8000);
    for (int b = 0; b < 4; b++) begin
      wr(ra(b, OFF_TRIG), 16'hFFFF);
      wr(ra(b, OFF_EPOL), 16'hFFFF);
      for (int i = 0; i < 16; i++) begin
        wr(ra(b, OFF_MASK), ~(16'h1 << i));
        gpio_in[b*16 + i] = 1'b1;
        tick(3);
        chk_reg("R4 rise", ra(b, OFF_STS), 16'h1 << i);
        chk_reg("R8 bank pend", STS_A, 16'h1 << b);
        check("R9 irq", {15'd0, irq_out}, 16'h0001);
        gpio_in[b*16 + i] = 1'b0;
        tick(3);
        chk_reg("R7 sticky", ra(b, OFF_STS), 16'h1 << i);
        wr(ra(b, OFF_STS), 16'h0000);
        chk_reg("R7 clear", ra(b, OFF_STS), 16'h0000);
        check("R9 irq off", {15'd0, irq_out}, 16'h0000);
      end
      wr(ra(b, OFF_MASK), 16'hFFFF);
    end

    // R4 falling sweep, one bank
    wr(ra(1, OFF_EPOL), 16'h0000);
    for (int i = 0; i < 16; i++) begin
      wr(ra(1, OFF_MASK), ~(16'h1 << i));
      gpio_in[16 + i] = 1'b1;
      tick(3);
      chk_reg("R4 no rise", ra(1, OFF_STS), 16'h0000);
      gpio_in[16 + i] = 1'b0;
      tick(3);
      chk_reg("R4 fall", ra(1, OFF_STS), 16'h1 << i);
      wr(ra(1, OFF_STS), 16'h0000);
    end
    wr(ra(1, OFF_MASK), 16'hFFFF);

    // R5 level high, bank 1 pin 7
    wr(ra(1, OFF_TRIG), 16'h0000);
    wr(ra(1, OFF_LPOL), 16'hFFFF);
    wr(ra(1, OFF_STS), 16'h0000);
    wr(ra(1, OFF_MASK), ~16'h0080);
    tick(2);
    chk_reg("R5 idle", ra(1, OFF_STS), 16'h0000);
    gpio_in[23] = 1'b1;
    tick(3);
    chk_reg("R5 high", ra(1, OFF_STS), 16'h0080);
    wr(ra(1, OFF_STS), 16'h0000);
    chk_reg("R5 reassert", ra(1, OFF_STS), 16'h0080);
    gpio_in[23] = 1'b0;
    tick(3);
    wr(ra(1, OFF_STS), 16'h0000);
    chk_reg("R5 released", ra(1, OFF_STS), 16'h0000);
    wr(ra(1, OFF_MASK), 16'hFFFF);

    // R5 level low, bank 2 pin 5
    wr(ra(2, OFF_TRIG), 16'h0000);
    wr(ra(2, OFF_LPOL), 16'h0000);
    wr(ra(2, OFF_STS), 16'h0000);
    wr(ra(2, OFF_MASK), ~16'h0020);
    tick(1);
    chk_reg("R5 low", ra(2, OFF_STS), 16'h0020);
    gpio_in[37] = 1'b1;
    tick(3);
    wr(ra(2, OFF_STS), 16'h0000);
    chk_reg("R5 low released", ra(2, OFF_STS), 16'h0000);
    wr(ra(2, OFF_MASK), 16'hFFFF);
    gpio_in[37] = 1'b0;
    tick(3);

    // R6 masking, bank 3 pin 0
    wr(ra(3, OFF_EPOL), 16'hFFFF);
    gpio_in[48] = 1'b1;
    tick(3);
    chk_reg("R6 blocked", ra(3, OFF_STS), 16'h0000);
    check("R6 irq", {15'd0, irq_out}, 16'h0000);
    gpio_in[48] = 1'b0;
    wr(ra(3, OFF_MASK), 16'hFFFE);
    tick(3);
    gpio_in[48] = 1'b1;
    tick(3);
    check("R6 unmasked irq", {15'd0, irq_out}, 16'h0001);
    wr(ra(3, OFF_MASK), 16'hFFFF);
    chk_reg("R6 kept", ra(3, OFF_STS), 16'h0001);
    chk_reg("R6 pend hidden", STS_A, 16'h0000);
    check("R6 irq hidden", {15'd0, irq_out}, 16'h0000);
    wr(ra(3, OFF_STS), 16'h0000);
    gpio_in[48] = 1'b0;

    // R7 partial clear, bank 0 pins 2 and 3
    wr(ra(0, OFF_MASK), ~16'h000C);
    gpio_in[3:2] = 2'b11;
    tick(3);
    chk_reg("R7 both", ra(0, OFF_STS), 16'h000C);
    wr(ra(0, OFF_STS), 16'h0008);
    chk_reg("R7 partial", ra(0, OFF_STS), 16'h0008);
    wr(ra(0, OFF_STS), 16'h0000);
    chk_reg("R7 all", ra(0, OFF_STS), 16'h0000);
    gpio_in[3:2] = 2'b00;
    wr(ra(0, OFF_MASK), 16'hFFFF);

    // R8 / R9 non-GPIO sources
    wr(CTL_A, 16'hFFFF);
    chk_reg("R9 ctl bits", CTL_A, 16'h83F0);
    wr(CTL_A, 16'h8000);
    for (int j = 0; j < 6; j++) begin
      ext_src = 6'(1 << j);
      tick(1);
      chk_reg("R8 ext", STS_A, 16'h1 << (4 + j));
      check("R9 not enabled", {15'd0, irq_out}, 16'h0000);
      wr(CTL_A, 16'h8000 | (16'h1 << (4 + j)));
      check("R9 enabled", {15'd0, irq_out}, 16'h0001);
      wr(CTL_A, 16'h1 << (4 + j));
      check("R9 global off", {15'd0, irq_out}, 16'h0000);
      wr(CTL_A, 16'h8000);
      ext_src = '0;
    end
    tick(1);
    chk_reg("R8 quiet", STS_A, 16'h0000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule